// File: doc/BRIEF.md
# Edge-Position Histogram Jitter Monitor

This block judges the quality of a received data eye from timing rather than amplitude. Every unit interval (UI) it receives a vector of binary samples taken at evenly spaced phases across the region where the data transition is expected. Adjacent samples are compared, and a mismatch between two neighbours marks the phase gap in which the data edge fell. Each gap has its own counter. Over a measurement window the counters build a histogram of edge positions. A tight histogram means little jitter and a wide horizontal eye. A spread histogram means a closing eye.

Software or a calibration engine clears the bins and loads a window length in UIs. It then pulses start. When done rises, it reads the bins and a width figure. The width figure is the span between the first and the last bins whose count exceeds a programmable threshold. The phase generator and the samplers themselves sit outside this block.

Top module: `ehm_monitor`

## Requirements
- R1: Edge position k (0 to NUM_PHASES-2) is active in a UI when samp_i[k] differs from samp_i[k+1]. Each counted UI adds one to bin k for every active position k. Bin k is presented on bins_o[k*CNT_W +: CNT_W].
- R2: When several positions are active in the same counted UI, every one of them is incremented in that UI.
- R3: A bin at full scale (all ones) stays at full scale on further edges and never wraps.
- R4: A start pulse while not busy captures win_len_i and raises busy_o on the next edge. The UI offered in the start cycle is not counted. After exactly win_len_i valid UIs, busy_o falls and done_o rises on the edge that counts the last UI.
- R5: While not busy (idle or done), valid samples leave every bin unchanged.
- R6: A cycle with samp_valid_i low counts nothing and does not advance the window.
- R7: A start pulse while busy is ignored. The window neither restarts nor extends.
- R8: clear_i zeroes all bins and drops busy_o and done_o on the next edge. It takes priority over start and counting.
- R9: width_o equals last-first+1, where first and last are the lowest and highest bins whose count is strictly greater than thresh_i. It is 0 when no bin qualifies. It is registered, so it reflects the bins and threshold as they stood one edge earlier.
- R10: After reset all bins, busy_o, done_o and width_o are zero.
- R11: A start with win_len_i equal to zero raises done_o on the next edge without counting any UI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one UI per valid cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Zero bins and abort the window |
| start_i | input | 1 | Begin a measurement window |
| win_len_i | input | WIN_W | Window length in valid UIs, captured at start |
| thresh_i | input | CNT_W | Count threshold used by the width figure |
| samp_valid_i | input | 1 | samp_i holds a new UI |
| samp_i | input | NUM_PHASES | Phase samples, bit 0 earliest |
| bins_o | output | (NUM_PHASES-1)*CNT_W | Flattened histogram bins |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | Window finished, bins frozen |
| width_o | output | $clog2(NUM_PHASES) | Span of bins above threshold |

## Verification
The bench feeds every possible 8-phase sample pattern through two back-to-back windows. The small 4-bit counters saturate heavily during this run. A design that wraps would show low counts in the busiest bins, and one that drops simultaneous edges would undercount the alternating patterns. Window boundaries are probed with stalled valid cycles, a start pulse in mid-window, a zero length and a mid-window clear. Each of these shows up as an early or late done, or as one stray count. The width figure is swept over every threshold after the histogram is built, which exposes off-by-one spans, a non-strict comparison and a wrong empty result.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_RUN  = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/ehm_edge_detect.sv
module ehm_edge_detect #(
  parameter int NUM_PHASES = 8,
  localparam int NUM_BINS = NUM_PHASES - 1
) (
  input  logic [NUM_PHASES-1:0] samp_i,
  output logic [NUM_BINS-1:0]   edge_o
);
  for (genvar k = 0; k < NUM_BINS; k++) begin : g_edge
    assign edge_o[k] = samp_i[k] ^ samp_i[k+1];
  end
endmodule

// File: rtl/ehm_bin_counter.sv
module ehm_bin_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             sat;

  assign sat = (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (inc_i && !sat)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  a_r3_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_o == CntMax) |=> (cnt_o == CntMax));
  a_r1_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i && cnt_o != CntMax) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
  a_r5_no_inc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clear_i) |=> $stable(cnt_o));
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_o == '0));
endmodule

// File: rtl/ehm_window_ctrl.sv
module ehm_window_ctrl
  import ehm_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             count_en_o,
  output logic             busy_o,
  output logic             done_o
);
  win_state_e       state_q;
  logic [WIN_W-1:0] len_q;
  logic [WIN_W-1:0] ui_q;
  logic             last_ui;

  assign last_ui = (ui_q == len_q - WIN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      len_q   <= '0;
      ui_q    <= '0;
    end else if (clear_i) begin
      state_q <= WIN_IDLE;
      ui_q    <= '0;
    end else begin
      case (state_q)
        WIN_IDLE, WIN_DONE: begin
          if (start_i) begin
            len_q   <= win_len_i;
            ui_q    <= '0;
            state_q <= (win_len_i == '0) ? WIN_DONE : WIN_RUN;
          end
        end
        WIN_RUN: begin
          if (valid_i) begin
            if (last_ui) state_q <= WIN_DONE;
            else         ui_q    <= ui_q + WIN_W'(1);
          end
        end
        default: state_q <= WIN_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == WIN_RUN);
  assign done_o     = (state_q == WIN_DONE);
  assign count_en_o = busy_o && valid_i && !clear_i;

  a_r4_done_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(clear_i)) |-> done_o);
  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !valid_i && !clear_i) |=> (busy_o && $stable(ui_q)));
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !clear_i && !valid_i) |=> (busy_o && $stable(len_q)));
  a_r8_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!busy_o && !done_o));
  a_r4_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/ehm_width_calc.sv
module ehm_width_calc #(
  parameter int NUM_BINS = 7,
  parameter int CNT_W    = 12,
  localparam int WID_W   = $clog2(NUM_BINS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BINS*CNT_W-1:0] bins_i,
  input  logic [CNT_W-1:0]          thresh_i,
  output logic [WID_W-1:0]          width_o
);
  logic [WID_W-1:0] first_idx, last_idx, width_d, width_q;
  logic             found;

  always_comb begin
    found     = 1'b0;
    first_idx = '0;
    last_idx  = '0;
    for (int k = 0; k < NUM_BINS; k++) begin
      if (bins_i[k*CNT_W +: CNT_W] > thresh_i) begin
        if (!found) first_idx = WID_W'(k);
        last_idx = WID_W'(k);
        found    = 1'b1;
      end
    end
    width_d = found ? (last_idx - first_idx + WID_W'(1)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) width_q <= '0;
    else         width_q <= width_d;
  end

  assign width_o = width_q;

  a_r9_width_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_o <= WID_W'(NUM_BINS));
endmodule

// File: rtl/ehm_monitor.sv
module ehm_monitor #(
  parameter int NUM_PHASES = 8,
  parameter int CNT_W      = 12,
  parameter int WIN_W      = 16,
  localparam int NUM_BINS  = NUM_PHASES - 1,
  localparam int WID_W     = $clog2(NUM_BINS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      start_i,
  input  logic [WIN_W-1:0]          win_len_i,
  input  logic [CNT_W-1:0]          thresh_i,
  input  logic                      samp_valid_i,
  input  logic [NUM_PHASES-1:0]     samp_i,
  output logic [NUM_BINS*CNT_W-1:0] bins_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [WID_W-1:0]          width_o
);
  logic [NUM_BINS-1:0] edge_vec;
  logic                count_en;

  ehm_edge_detect #(.NUM_PHASES(NUM_PHASES)) u_edge (
    .samp_i (samp_i),
    .edge_o (edge_vec)
  );

  ehm_window_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .start_i    (start_i),
    .valid_i    (samp_valid_i),
    .win_len_i  (win_len_i),
    .count_en_o (count_en),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    ehm_bin_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .inc_i   (count_en && edge_vec[k]),
      .cnt_o   (bins_o[k*CNT_W +: CNT_W])
    );
  end

  ehm_width_calc #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W)) u_width (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bins_i   (bins_o),
    .thresh_i (thresh_i),
    .width_o  (width_o)
  );

  // bins may only move while a window runs or on clear
  a_r5_frozen_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !clear_i) |=> $stable(bins_o));
endmodule

// File: tb/ehm_monitor_test.sv
`timescale 1ns/1ps
module ehm_monitor_test;
  localparam int P  = 8;
  localparam int CW = 4;
  localparam int WW = 8;
  localparam int NB = P - 1;
  localparam int WD = $clog2(NB + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            clear_i = 1'b0;
  logic            start_i = 1'b0;
  logic [WW-1:0]   win_len_i = '0;
  logic [CW-1:0]   thresh_i = '0;
  logic            samp_valid_i = 1'b0;
  logic [P-1:0]    samp_i = '0;
  logic [NB*CW-1:0] bins_o;
  logic            busy_o, done_o;
  logic [WD-1:0]   width_o;

  int checks = 0;
  int errors = 0;

  int m_bins[NB];
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0, m_len = 0;

  always #2 clk_i = ~clk_i;

  ehm_monitor #(.NUM_PHASES(P), .CNT_W(CW), .WIN_W(WW)) uut (
    .clk_i, .rst_ni, .clear_i, .start_i, .win_len_i, .thresh_i,
    .samp_valid_i, .samp_i, .bins_o, .busy_o, .done_o, .width_o
  );

  function automatic int bin_at(int k);
    return int'(bins_o[k*CW +: CW]);
  endfunction

  function automatic int wmodel(int thr);
    int first = -1, last = -1;
    for (int k = 0; k < NB; k++)
      if (m_bins[k] > thr) begin
        if (first < 0) first = k;
        last = k;
      end
    return (first < 0) ? 0 : last - first + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit st, input bit clr, input bit v, input logic [P-1:0] p);
    int wexp;
    bit en;
    wexp = wmodel(int'(thresh_i));
    if (clr) begin
      for (int k = 0; k < NB; k++) m_bins[k] = 0;
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      en = m_busy && v;
      if (st && !m_busy) begin
        m_len = int'(win_len_i);
        m_cnt = 0;
        if (m_len == 0) begin m_done = 1; m_busy = 0; end
        else begin m_busy = 1; m_done = 0; end
      end else if (m_busy && v) begin
        if (m_cnt == m_len - 1) begin m_busy = 0; m_done = 1; end
        else m_cnt++;
      end
      if (en)
        for (int k = 0; k < NB; k++)
          if (p[k] != p[k+1] && m_bins[k] < CMAX) m_bins[k]++;
    end
    start_i = st; clear_i = clr; samp_valid_i = v; samp_i = p;
    @(negedge clk_i);
    start_i = 0; clear_i = 0; samp_valid_i = 0;
    for (int k = 0; k < NB; k++)
      chk(bin_at(k) == m_bins[k], $sformatf("R1 bin %0d", k), bin_at(k), m_bins[k]);
    chk(busy_o == m_busy, "R4 busy", busy_o, m_busy);
    chk(done_o == m_done, "R4 done", done_o, m_done);
    chk(int'(width_o) == wexp, "R9 width", width_o, wexp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap[NB];
    for (int k = 0; k < NB; k++) m_bins[k] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(bins_o == '0, "R10 bins", int'(bins_o), 0);
    chk(!busy_o && !done_o, "R10 flags", {busy_o, done_o}, 0);
    chk(width_o == '0, "R10 width", width_o, 0);

    // R11 zero-length window
    win_len_i = 0;
    cyc(1, 0, 1, 8'h01);
    chk(done_o == 1 && bins_o == '0, "R11 zero len", done_o, 1);

    // R1 single edges, start-cycle sample not counted
    cyc(0, 1, 0, 0);
    win_len_i = 4;
    cyc(1, 0, 1, 8'h0F);
    cyc(0, 0, 1, 8'b0000_0011);
    cyc(0, 0, 1, 8'b0000_0000);
    cyc(0, 0, 1, 8'b1111_1110);
    cyc(0, 0, 1, 8'b1000_0000);
    chk(bin_at(1) == 1 && bin_at(0) == 1 && bin_at(6) == 1 && bin_at(3) == 0,
        "R1 hand bins", bin_at(1), 1);
    chk(done_o == 1, "R4 done after 4", done_o, 1);
    thresh_i = 0; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk(width_o == 3'd7, "R9 span 0..6", width_o, 7);
    thresh_i = 1; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk(width_o == 3'd0, "R9 strict empty", width_o, 0);

    // R5 frozen after done
    for (int k = 0; k < NB; k++) snap[k] = bin_at(k);
    repeat (3) cyc(0, 0, 1, 8'h55);
    for (int k = 0; k < NB; k++)
      chk(bin_at(k) == snap[k], "R5 frozen", bin_at(k), snap[k]);

    // R2 multiple edges in one UI
    cyc(0, 1, 0, 0);
    win_len_i = 2;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 8'b0101_0101);
    cyc(0, 0, 1, 8'b0011_1100);
    chk(bin_at(1) == 2 && bin_at(5) == 2 && bin_at(0) == 1 && bin_at(6) == 1,
        "R2 multi", bin_at(1), 2);

    // R6 stalled UIs
    cyc(0, 1, 0, 0);
    win_len_i = 3;
    cyc(1, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 8'hFE);
    chk(busy_o == 1 && bins_o == '0, "R6 stall", busy_o, 1);
    repeat (3) cyc(0, 0, 1, 8'h01);
    chk(done_o == 1 && bin_at(0) == 3, "R6 count", bin_at(0), 3);

    // R7 start while busy ignored
    cyc(0, 1, 0, 0);
    win_len_i = 4;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 8'h03);
    cyc(0, 0, 1, 8'h03);
    win_len_i = 9;
    cyc(1, 0, 1, 8'h03);
    chk(busy_o == 1, "R7 still busy", busy_o, 1);
    cyc(0, 0, 1, 8'h03);
    chk(done_o == 1 && bin_at(1) == 4, "R7 no restart", done_o, 1);

    // R8 clear mid-window
    win_len_i = 10;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 8'hF0);
    cyc(0, 0, 1, 8'hF0);
    cyc(1, 1, 1, 8'hF0);
    chk(bins_o == '0 && !busy_o && !done_o, "R8 clear", int'(bins_o), 0);

    // R3 exhaustive pattern sweep, two windows, saturating
    win_len_i = 128;
    cyc(1, 0, 0, 0);
    for (int p = 0; p < 128; p++) cyc(0, 0, 1, p[P-1:0]);
    cyc(1, 0, 0, 0);
    for (int p = 128; p < 256; p++) cyc(0, 0, 1, p[P-1:0]);
    chk(bin_at(0) == CMAX && bin_at(6) == CMAX, "R3 saturate", bin_at(0), CMAX);

    // R9 threshold sweep on saturated histogram, then partial histogram
    for (int t = 0; t <= CMAX; t++) begin
      thresh_i = CW'(t);
      cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
      chk(int'(width_o) == wmodel(t), "R9 sweep", width_o, wmodel(t));
    end
    cyc(0, 1, 0, 0);
    win_len_i = 6;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, (i < 3) ? 8'h07 : 8'h1F);
    for (int t = 0; t <= 6; t++) begin
      thresh_i = CW'(t);
      cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
      chk(int'(width_o) == wmodel(t), "R9 partial", width_o, wmodel(t));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule